// File: doc/BRIEF.md
# Display Link Auxiliary Request Engine

This block issues request packets on a display link's auxiliary side channel and interprets the replies. It supports native register reads, native register writes, and single-byte I2C transfers tunnelled over the side channel. A host starts a transaction with a one-cycle `go` strobe. Along with the strobe it presents a command kind, a 16-bit address, a byte length, write data and three I2C mode flags (start, stop, read). The engine builds a four-byte request header and hands it to a lower-level transfer engine. That engine is modelled here as a request/response port that returns a status code, a reply byte, a byte count and data.

The engine classifies each reply. A transaction either finishes, retries at once, or retries after a timed back-off counted in microseconds, which come from a parameterised clock divider. The number of attempts is bounded. When a transaction ends, the engine raises `done` for one cycle together with a result code, the number of bytes received or written, and the received data. Electrical signalling and wire-level clock recovery sit below the transfer port and are not part of this block.

Top module: `auxreq_engine`

## Requirements
- R1: Header byte 0 is the address low byte and byte 1 the address high byte. Byte 2 holds the command in its upper nibble: 9 for a native read, 8 for a native write. Byte 3 is the low four bits of the message byte count in its upper nibble and (length − 1) in its lower nibble. The message byte count is 4 for a read and 4 + length for a write. `xfer_hdr` carries byte 0 in bits [7:0] and byte 3 in bits [31:24]. `xfer_len` is the message byte count. A native write carries its first `length` bytes on `xfer_wdata`.
- R2: A native write whose length exceeds MAX_BYTES finishes with result 6 (too long) and issues no request.
- R3: A transaction makes at most MAX_TRIES attempts. Transfer status 4 (busy) uses up one attempt and is retried without waiting. If the attempts run out on a busy or defer reply, the result is 5 (retries exhausted).
- R4: Transfer status 1 gives result 1 (timeout). Status 2 or 3 gives result 2 (I/O error). Neither is retried, and both report a count of 0.
- R5: With status 0, reply bits [5:4] form the link reply code (0 ack, 1 nack, 2 defer). A native ack gives result 0. For a write, the count equals the length.
- R6: A defer reply waits DEFER_US microsecond ticks (CLKS_PER_US clocks each) before the next attempt.
- R7: A native nack, or link code 3, gives result 2. For a native read with a returned byte count of zero, the result is 3 (protocol error) instead.
- R8: The received count of a native read is the returned byte count clamped to the requested length. Byte i of `rd_data` holds received byte i below the count and zero above it.
- R9: An I2C command is selected when `cmd_kind[1]` is 1. Its command nibble is 1 for a read and 0 for a write, with 4 added unless stop is set. Byte 3 is 0x30 when start or stop is set. Otherwise it is 0x40 for a read and 0x50 for a write. The message count is 4 for a read and 5 for a write, and the write byte travels in byte 0 of `xfer_wdata`.
- R10: For I2C, the link code is checked first. A link nack or code 3 gives result 4 (remote error), and a link defer backs off and retries.
- R11: After a link ack, reply bits [7:6] form the I2C code (0 ack, 1 nack, 2 defer, 3 invalid). An I2C ack gives result 0 with the count clamped to 1. The received byte is delivered only for a plain read with neither start nor stop. An I2C nack or invalid code gives result 4, and an I2C defer backs off and retries.
- R12: After reset, `busy`, `done` and `xfer_valid` are low. `xfer_valid` and `done` are single-cycle pulses, and `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe, accepted when idle |
| cmd_kind | input | 2 | 0 native read, 1 native write, 2 or 3 I2C |
| cmd_addr | input | 16 | Target address |
| cmd_len | input | LW | Byte length of a native transfer |
| cmd_wdata | input | MAX_BYTES*8 | Write data, byte 0 in the low bits |
| i2c_start | input | 1 | I2C start flag |
| i2c_stop | input | 1 | I2C stop flag |
| i2c_read | input | 1 | I2C read flag |
| xfer_valid | output | 1 | One-cycle request to the transfer engine |
| xfer_hdr | output | 32 | Request header bytes 0..3 |
| xfer_len | output | LW+1 | Message byte count |
| xfer_wdata | output | MAX_BYTES*8 | Request payload |
| xfer_done | input | 1 | Transfer engine reply strobe |
| xfer_status | input | 3 | 0 ok, 1 timeout, 2 flags, 3 error, 4 busy |
| xfer_reply | input | 8 | Reply byte |
| xfer_rlen | input | LW | Returned byte count |
| xfer_rdata | input | MAX_BYTES*8 | Returned data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 timeout, 2 I/O, 3 protocol, 4 remote, 5 retries exhausted, 6 too long |
| rd_count | output | LW | Byte count of the completed transfer |
| rd_data | output | MAX_BYTES*8 | Received data |

## Verification
Native writes are swept over every legal length. This tells apart the wrapping of the message count in header byte 3 from the length field, and it shows that exactly the requested payload bytes travel. All eight I2C flag combinations are driven. They separate the effect of the continuation bit, the address-only header for start and stop, and the rule that data is delivered only for a plain read. Scripted reply sequences cover the following cases:
- runs of busy replies and runs of defers, which separate an immediate retry from a timed back-off and show where the attempt limit falls;
- each failing status;
- native and I2C nack codes, which separate the I/O, protocol and remote error results;
- oversize returned byte counts, which exercise the clamp.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;

    // transfer engine status codes
    localparam logic [2:0] XS_OK      = 3'd0;
    localparam logic [2:0] XS_TIMEOUT = 3'd1;
    localparam logic [2:0] XS_FLAGS   = 3'd2;
    localparam logic [2:0] XS_ERROR   = 3'd3;
    localparam logic [2:0] XS_BUSY    = 3'd4;

    // request command nibbles
    localparam logic [3:0] CMD_NWR    = 4'h8;
    localparam logic [3:0] CMD_NRD    = 4'h9;
    localparam logic [3:0] CMD_I2C_WR = 4'h0;
    localparam logic [3:0] CMD_I2C_RD = 4'h1;
    localparam logic [3:0] CMD_MOT    = 4'h4;

    // two-bit reply codes, both layers
    localparam logic [1:0] RPL_ACK   = 2'd0;
    localparam logic [1:0] RPL_NACK  = 2'd1;
    localparam logic [1:0] RPL_DEFER = 2'd2;

    typedef enum logic [2:0] {
        RES_OK          = 3'd0,
        RES_TIMEOUT     = 3'd1,
        RES_IO_ERR      = 3'd2,
        RES_PROTO_ERR   = 3'd3,
        RES_REMOTE_ERR  = 3'd4,
        RES_RETRIES_OUT = 3'd5,
        RES_TOO_LONG    = 3'd6
    } result_e;

    typedef enum logic [1:0] {
        ACT_FINISH     = 2'd0,
        ACT_RETRY_NOW  = 2'd1,
        ACT_RETRY_WAIT = 2'd2
    } act_e;

    typedef struct packed {
        act_e    act;
        result_e res;
    } verdict_t;

    typedef enum logic [2:0] {
        F_IDLE, F_ISSUE, F_WAIT, F_BACKOFF, F_FINISH
    } fsm_e;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic        i2c_start;
        logic        i2c_stop;
        logic        i2c_read;
    } req_t;

    function automatic logic kind_is_i2c(input logic [1:0] k);
        return k[1];
    endfunction

    function automatic logic kind_is_nwr(input logic [1:0] k);
        return k == 2'd1;
    endfunction

endpackage

// File: rtl/auxreq_tick.sv
module auxreq_tick #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)               div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    generate
        if (CLKS_PER_US > 1) begin : g_spacing
            p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/auxreq_hdr.sv
module auxreq_hdr
    import auxreq_pkg::*;
#(
    parameter int LW = 5
) (
    input  req_t          rq,
    input  logic [LW-1:0] len,
    output logic [31:0]   hdr,
    output logic [LW:0]   msg_bytes
);
    logic [3:0]  cmd;
    logic [7:0]  b3;
    logic [LW-1:0] len_m1;

    assign len_m1 = len - 1'b1;

    always_comb begin
        cmd       = CMD_NRD;
        msg_bytes = (LW+1)'(4);
        b3        = 8'h00;
        if (kind_is_i2c(rq.kind)) begin
            cmd       = (rq.i2c_read ? CMD_I2C_RD : CMD_I2C_WR) | (rq.i2c_stop ? 4'h0 : CMD_MOT);
            msg_bytes = rq.i2c_read ? (LW+1)'(4) : (LW+1)'(5);
            b3        = (rq.i2c_start || rq.i2c_stop) ? 8'h30 : {msg_bytes[3:0], 4'h0};
        end else if (kind_is_nwr(rq.kind)) begin
            cmd       = CMD_NWR;
            msg_bytes = (LW+1)'(4) + {1'b0, len};
            b3        = {msg_bytes[3:0], len_m1[3:0]};
        end else begin
            cmd       = CMD_NRD;
            msg_bytes = (LW+1)'(4);
            b3        = {msg_bytes[3:0], len_m1[3:0]};
        end
    end

    assign hdr = {b3, cmd, 4'h0, rq.addr[15:8], rq.addr[7:0]};
endmodule

// File: rtl/auxreq_judge.sv
module auxreq_judge
    import auxreq_pkg::*;
(
    input  logic       i2c_mode,
    input  logic       native_rd,
    input  logic [2:0] status,
    input  logic [7:0] reply,
    input  logic       rlen_zero,
    output verdict_t   verdict
);
    logic [1:0] link_code;
    logic [1:0] bus_code;

    assign link_code = reply[5:4];
    assign bus_code  = reply[7:6];

    always_comb begin
        verdict.act = ACT_FINISH;
        verdict.res = RES_IO_ERR;
        case (status)
            XS_BUSY:    verdict.act = ACT_RETRY_NOW;
            XS_TIMEOUT: verdict.res = RES_TIMEOUT;
            XS_OK: begin
                if (link_code == RPL_DEFER) begin
                    verdict.act = ACT_RETRY_WAIT;
                end else if (link_code == RPL_ACK) begin
                    if (!i2c_mode) begin
                        verdict.res = RES_OK;
                    end else begin
                        case (bus_code)
                            RPL_ACK:   verdict.res = RES_OK;
                            RPL_DEFER: verdict.act = ACT_RETRY_WAIT;
                            default:   verdict.res = RES_REMOTE_ERR;
                        endcase
                    end
                end else if (i2c_mode) begin
                    verdict.res = RES_REMOTE_ERR;
                end else if (native_rd && rlen_zero) begin
                    verdict.res = RES_PROTO_ERR;
                end else begin
                    verdict.res = RES_IO_ERR;
                end
            end
            default:    verdict.res = RES_IO_ERR;
        endcase
    end
endmodule

// File: rtl/auxreq_engine.sv
module auxreq_engine
    import auxreq_pkg::*;
#(
    parameter int MAX_BYTES   = 16,
    parameter int MAX_TRIES   = 7,
    parameter int CLKS_PER_US = 100,
    parameter int DEFER_US    = 450,
    localparam int LW = $clog2(MAX_BYTES + 1),
    localparam int DW = MAX_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [1:0]    cmd_kind,
    input  logic [15:0]   cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          i2c_start,
    input  logic          i2c_stop,
    input  logic          i2c_read,
    output logic          xfer_valid,
    output logic [31:0]   xfer_hdr,
    output logic [LW:0]   xfer_len,
    output logic [DW-1:0] xfer_wdata,
    input  logic          xfer_done,
    input  logic [2:0]    xfer_status,
    input  logic [7:0]    xfer_reply,
    input  logic [LW-1:0] xfer_rlen,
    input  logic [DW-1:0] xfer_rdata,
    output logic          busy,
    output logic          done,
    output logic [2:0]    result,
    output logic [LW-1:0] rd_count,
    output logic [DW-1:0] rd_data
);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam int BW = (DEFER_US > 0) ? $clog2(DEFER_US + 1) : 1;
    localparam logic [LW-1:0] LEN_MAX   = LW'(MAX_BYTES);
    localparam logic [TW-1:0] TRIES_MAX = TW'(MAX_TRIES);
    localparam logic [BW-1:0] WAIT_LOAD = BW'(DEFER_US);

    fsm_e          fsm_q;
    req_t          req_q;
    logic [LW-1:0] len_q;
    logic [DW-1:0] wdata_q;
    logic [TW-1:0] tries_q;
    logic [BW-1:0] wait_q;
    result_e       result_q;
    logic [LW-1:0] count_q;
    logic [DW-1:0] data_q;

    logic          us_tick;
    verdict_t      verdict;
    logic          is_i2c_q;
    logic          is_nwr_q;
    logic          plain_i2c_rd;
    logic          keep_data;
    logic [LW-1:0] cap;
    logic [LW-1:0] cnt_ok;
    logic [DW-1:0] data_ok;
    logic          tries_spent;

    auxreq_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (us_tick)
    );

    auxreq_hdr #(.LW(LW)) u_hdr (
        .rq        (req_q),
        .len       (len_q),
        .hdr       (xfer_hdr),
        .msg_bytes (xfer_len)
    );

    auxreq_judge u_judge (
        .i2c_mode  (is_i2c_q),
        .native_rd (!is_i2c_q && !is_nwr_q),
        .status    (xfer_status),
        .reply     (xfer_reply),
        .rlen_zero (xfer_rlen == '0),
        .verdict   (verdict)
    );

    assign is_i2c_q     = kind_is_i2c(req_q.kind);
    assign is_nwr_q     = !is_i2c_q && kind_is_nwr(req_q.kind);
    assign plain_i2c_rd = is_i2c_q && req_q.i2c_read && !req_q.i2c_start && !req_q.i2c_stop;
    assign keep_data    = (!is_i2c_q && !is_nwr_q) || plain_i2c_rd;
    assign cap          = is_i2c_q ? LW'(1) : len_q;
    assign cnt_ok       = is_nwr_q ? len_q : ((xfer_rlen > cap) ? cap : xfer_rlen);
    assign tries_spent  = (tries_q >= TRIES_MAX);

    generate
        for (genvar b = 0; b < MAX_BYTES; b++) begin : g_rx_byte
            assign data_ok[b*8 +: 8] = (keep_data && (LW'(b) < cnt_ok)) ? xfer_rdata[b*8 +: 8] : 8'h00;
        end
    endgenerate

    assign xfer_wdata = (is_nwr_q || (is_i2c_q && !req_q.i2c_read)) ? wdata_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q    <= F_IDLE;
            req_q    <= '0;
            len_q    <= '0;
            wdata_q  <= '0;
            tries_q  <= '0;
            wait_q   <= '0;
            result_q <= RES_OK;
            count_q  <= '0;
            data_q   <= '0;
        end else begin
            case (fsm_q)
                F_IDLE: begin
                    if (go) begin
                        req_q   <= '{kind: cmd_kind, addr: cmd_addr, i2c_start: i2c_start,
                                     i2c_stop: i2c_stop, i2c_read: i2c_read};
                        len_q   <= cmd_len;
                        wdata_q <= cmd_wdata;
                        tries_q <= '0;
                        count_q <= '0;
                        data_q  <= '0;
                        if (kind_is_nwr(cmd_kind) && (cmd_len > LEN_MAX)) begin
                            result_q <= RES_TOO_LONG;
                            fsm_q    <= F_FINISH;
                        end else begin
                            fsm_q <= F_ISSUE;
                        end
                    end
                end
                F_ISSUE: begin
                    tries_q <= tries_q + 1'b1;
                    fsm_q   <= F_WAIT;
                end
                F_WAIT: begin
                    if (xfer_done) begin
                        case (verdict.act)
                            ACT_RETRY_NOW: begin
                                if (tries_spent) begin
                                    result_q <= RES_RETRIES_OUT;
                                    fsm_q    <= F_FINISH;
                                end else begin
                                    fsm_q <= F_ISSUE;
                                end
                            end
                            ACT_RETRY_WAIT: begin
                                if (tries_spent) begin
                                    result_q <= RES_RETRIES_OUT;
                                    fsm_q    <= F_FINISH;
                                end else begin
                                    wait_q <= WAIT_LOAD;
                                    fsm_q  <= F_BACKOFF;
                                end
                            end
                            default: begin
                                result_q <= verdict.res;
                                if (verdict.res == RES_OK) begin
                                    count_q <= cnt_ok;
                                    data_q  <= data_ok;
                                end
                                fsm_q <= F_FINISH;
                            end
                        endcase
                    end
                end
                F_BACKOFF: begin
                    if (us_tick) begin
                        if (wait_q <= BW'(1)) fsm_q <= F_ISSUE;
                        else                  wait_q <= wait_q - 1'b1;
                    end
                end
                F_FINISH: fsm_q <= F_IDLE;
                default:  fsm_q <= F_IDLE;
            endcase
        end
    end

    assign xfer_valid = (fsm_q == F_ISSUE);
    assign busy       = (fsm_q != F_IDLE);
    assign done       = (fsm_q == F_FINISH);
    assign result     = result_q;
    assign rd_count   = count_q;
    assign rd_data    = data_q;

    p_issue_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |=> !xfer_valid);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_attempt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (tries_q < TRIES_MAX));

    p_no_long_write_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> !(is_nwr_q && (len_q > LEN_MAX)));

    p_count_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_count <= cap));

    p_fail_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (done && (result != 3'd0)) |-> (rd_count == '0));
endmodule

// File: tb/auxreq_engine_bench.sv
module auxreq_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MB  = 16;
    localparam int MT  = 7;
    localparam int CPU = 4;
    localparam int DUS = 3;
    localparam int LW  = 5;
    localparam int DW  = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go = 1'b0;
    logic [1:0]    cmd_kind = '0;
    logic [15:0]   cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          i2c_start = 1'b0, i2c_stop = 1'b0, i2c_read = 1'b0;
    logic          xfer_valid;
    logic [31:0]   xfer_hdr;
    logic [LW:0]   xfer_len;
    logic [DW-1:0] xfer_wdata;
    logic          xfer_done = 1'b0;
    logic [2:0]    xfer_status = '0;
    logic [7:0]    xfer_reply = '0;
    logic [LW-1:0] xfer_rlen = '0;
    logic [DW-1:0] xfer_rdata = '0;
    logic          busy, done;
    logic [2:0]    result;
    logic [LW-1:0] rd_count;
    logic [DW-1:0] rd_data;

    auxreq_engine #(.MAX_BYTES(MB), .MAX_TRIES(MT), .CLKS_PER_US(CPU), .DEFER_US(DUS)) u_auxreq_engine (
        .clk(clk), .rst(rst), .go(go), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .i2c_start(i2c_start), .i2c_stop(i2c_stop),
        .i2c_read(i2c_read), .xfer_valid(xfer_valid), .xfer_hdr(xfer_hdr), .xfer_len(xfer_len),
        .xfer_wdata(xfer_wdata), .xfer_done(xfer_done), .xfer_status(xfer_status),
        .xfer_reply(xfer_reply), .xfer_rlen(xfer_rlen), .xfer_rdata(xfer_rdata),
        .busy(busy), .done(done), .result(result), .rd_count(rd_count), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;

    logic [2:0]    sc_status [0:7];
    logic [7:0]    sc_reply  [0:7];
    logic [LW-1:0] sc_rlen   [0:7];
    logic [DW-1:0] sc_rdata  [0:7];
    int            gap       [0:7];
    logic [31:0]   seen_hdr;
    logic [LW:0]   seen_len;
    logic [DW-1:0] seen_wdata;
    int            n_req = 0;
    int            cyc = 0;
    int            last_resp = 0;
    bit            resp_pending = 0;
    int            resp_idx = 0;

    // transfer engine model: answers each request one cycle later from the script
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            xfer_done = 1'b0;
            if (resp_pending) begin
                xfer_status = sc_status[resp_idx];
                xfer_reply  = sc_reply[resp_idx];
                xfer_rlen   = sc_rlen[resp_idx];
                xfer_rdata  = sc_rdata[resp_idx];
                xfer_done   = 1'b1;
                resp_pending = 0;
                last_resp   = cyc;
            end
            if (xfer_valid) begin
                seen_hdr   = xfer_hdr;
                seen_len   = xfer_len;
                seen_wdata = xfer_wdata;
                if (n_req < 8) begin
                    gap[n_req] = cyc - last_resp;
                    resp_idx   = n_req;
                end
                n_req++;
                resp_pending = 1;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL R12 watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic fill(input logic [2:0] st, input logic [7:0] rp, input logic [LW-1:0] rl, input logic [DW-1:0] rd);
        for (int i = 0; i < 8; i++) begin
            sc_status[i] = st; sc_reply[i] = rp; sc_rlen[i] = rl; sc_rdata[i] = rd;
        end
    endtask

    task automatic slot(input int i, input logic [2:0] st, input logic [7:0] rp);
        sc_status[i] = st; sc_reply[i] = rp;
    endtask

    task automatic run(input logic [1:0] k, input logic [15:0] a, input logic [LW-1:0] l,
                       input logic [DW-1:0] wd, input logic s, input logic p, input logic r);
        @(negedge clk);
        n_req = 0;
        cmd_kind = k; cmd_addr = a; cmd_len = l; cmd_wdata = wd;
        i2c_start = s; i2c_stop = p; i2c_read = r;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        while (!done) @(negedge clk);
    endtask

    localparam logic [DW-1:0] RX_PAT = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset busy", DW'(busy), 0);
        check("R12 reset done", DW'(done), 0);
        check("R12 reset xfer_valid", DW'(xfer_valid), 0);
        rst = 1'b0;

        // R1 R5 R8: native read, full return
        fill(3'd0, 8'h00, 5'd6, RX_PAT);
        run(2'd0, 16'h1234, 5'd6, '0, 0, 0, 0);
        check("R1 read header", DW'(seen_hdr), DW'(32'h45901234));
        check("R1 read msg len", DW'(seen_len), 4);
        check("R5 read result", DW'(result), 0);
        check("R8 read count", DW'(rd_count), 6);
        check("R8 read data", rd_data, RX_PAT & {{80{1'b0}}, {48{1'b1}}});
        check("R3 one attempt", DW'(n_req), 1);
        @(negedge clk);
        check("R12 done single", DW'(done), 0);
        check("R12 idle after done", DW'(busy), 0);

        // R8: oversize return clamped
        fill(3'd0, 8'h00, 5'd9, RX_PAT);
        run(2'd0, 16'h0200, 5'd4, '0, 0, 0, 0);
        check("R8 clamp count", DW'(rd_count), 4);
        check("R8 clamp data", rd_data, RX_PAT & {{96{1'b0}}, {32{1'b1}}});

        // R1 R5: native write length sweep
        for (int L = 1; L <= MB; L++) begin
            logic [DW-1:0] wd;
            logic [DW-1:0] msk;
            for (int b = 0; b < MB; b++) wd[b*8 +: 8] = 8'(8'h10 + b + L);
            msk = {DW{1'b1}} >> (DW - 8*L);
            fill(3'd0, 8'h00, 5'd0, '0);
            run(2'd1, 16'hA55A, 5'(L), wd, 0, 0, 0);
            check($sformatf("R1 write header L=%0d", L), DW'(seen_hdr),
                  DW'({8'(((4 + L) % 16) * 16 + (L - 1)), 8'h80, 16'hA55A}));
            check($sformatf("R1 write msg len L=%0d", L), DW'(seen_len), DW'(4 + L));
            check($sformatf("R1 write payload L=%0d", L), seen_wdata & msk, wd & msk);
            check($sformatf("R5 write result L=%0d", L), DW'(result), 0);
            check($sformatf("R5 write count L=%0d", L), DW'(rd_count), DW'(L));
        end

        // R2: oversize write rejected
        run(2'd1, 16'h0010, 5'd17, '1, 0, 0, 0);
        check("R2 too long result", DW'(result), 6);
        check("R2 no request", DW'(n_req), 0);

        // R3: busy six times then ack
        fill(3'd4, 8'h00, 5'd1, RX_PAT);
        slot(6, 3'd0, 8'h00);
        run(2'd0, 16'h0001, 5'd1, '0, 0, 0, 0);
        check("R3 busy then ok result", DW'(result), 0);
        check("R3 busy then ok attempts", DW'(n_req), 7);
        for (int i = 1; i < 7; i++) check_range($sformatf("R3 immediate retry %0d", i), gap[i], 1, 1);

        // R3: busy every time
        fill(3'd4, 8'h00, 5'd1, RX_PAT);
        run(2'd0, 16'h0001, 5'd1, '0, 0, 0, 0);
        check("R3 exhausted result", DW'(result), 5);
        check("R3 exhausted attempts", DW'(n_req), MT);

        // R4: failing statuses
        for (int s = 1; s <= 3; s++) begin
            fill(3'(s), 8'h00, 5'd2, RX_PAT);
            run(2'd0, 16'h0300, 5'd2, '0, 0, 0, 0);
            check($sformatf("R4 status %0d result", s), DW'(result), (s == 1) ? 1 : 2);
            check($sformatf("R4 status %0d attempts", s), DW'(n_req), 1);
            check($sformatf("R4 status %0d count", s), DW'(rd_count), 0);
        end

        // R6: one defer then ack
        fill(3'd0, 8'h20, 5'd1, RX_PAT);
        slot(1, 3'd0, 8'h00);
        run(2'd0, 16'h0400, 5'd1, '0, 0, 0, 0);
        check("R6 defer result", DW'(result), 0);
        check("R6 defer attempts", DW'(n_req), 2);
        check_range("R6 defer wait", gap[1], (DUS - 1) * CPU + 2, DUS * CPU + 1);

        // R3 R6: defer every time
        fill(3'd0, 8'h20, 5'd1, RX_PAT);
        run(2'd1, 16'h0400, 5'd1, '0, 0, 0, 0);
        check("R3 defer exhausted result", DW'(result), 5);
        check("R3 defer exhausted attempts", DW'(n_req), MT);

        // R7: native error replies
        fill(3'd0, 8'h10, 5'd0, RX_PAT);
        run(2'd1, 16'h0500, 5'd2, '0, 0, 0, 0);
        check("R7 write nack", DW'(result), 2);
        run(2'd0, 16'h0500, 5'd2, '0, 0, 0, 0);
        check("R7 read nack empty", DW'(result), 3);
        fill(3'd0, 8'h10, 5'd2, RX_PAT);
        run(2'd0, 16'h0500, 5'd2, '0, 0, 0, 0);
        check("R7 read nack with data", DW'(result), 2);
        fill(3'd0, 8'h30, 5'd2, RX_PAT);
        run(2'd0, 16'h0500, 5'd2, '0, 0, 0, 0);
        check("R7 read invalid code", DW'(result), 2);

        // R9 R11: I2C flag sweep
        for (int f = 0; f < 8; f++) begin
            logic s, p, r;
            logic [7:0] e2, e3;
            s = f[0]; p = f[1]; r = f[2];
            e2 = {(r ? 4'h1 : 4'h0) | (p ? 4'h0 : 4'h4), 4'h0};
            e3 = (s || p) ? 8'h30 : (r ? 8'h40 : 8'h50);
            fill(3'd0, 8'h00, 5'd1, {120'h0, 8'hA5});
            run(2'd2, 16'h0050, 5'd1, {120'h0, 8'h3C}, s, p, r);
            check($sformatf("R9 i2c header f=%0d", f), DW'(seen_hdr), DW'({e3, e2, 16'h0050}));
            check($sformatf("R9 i2c msg len f=%0d", f), DW'(seen_len), r ? 4 : 5);
            if (!r) check($sformatf("R9 i2c write byte f=%0d", f), DW'(seen_wdata[7:0]), DW'(8'h3C));
            check($sformatf("R11 i2c result f=%0d", f), DW'(result), 0);
            check($sformatf("R11 i2c count f=%0d", f), DW'(rd_count), 1);
            check($sformatf("R11 i2c data f=%0d", f), rd_data, (r && !s && !p) ? DW'(8'hA5) : '0);
        end

        // R10: link layer first
        fill(3'd0, 8'h10, 5'd1, RX_PAT);
        run(2'd3, 16'h0050, 5'd1, '0, 0, 0, 1);
        check("R10 i2c link nack", DW'(result), 4);
        fill(3'd0, 8'h30, 5'd1, RX_PAT);
        run(2'd2, 16'h0050, 5'd1, '0, 0, 0, 1);
        check("R10 i2c link invalid", DW'(result), 4);
        fill(3'd0, 8'h20, 5'd1, RX_PAT);
        slot(1, 3'd0, 8'h00);
        run(2'd2, 16'h0050, 5'd1, '0, 0, 0, 1);
        check("R10 i2c link defer result", DW'(result), 0);
        check("R10 i2c link defer attempts", DW'(n_req), 2);
        check_range("R10 i2c link defer wait", gap[1], (DUS - 1) * CPU + 2, DUS * CPU + 1);

        // R11: I2C reply layer
        fill(3'd0, 8'h40, 5'd1, RX_PAT);
        run(2'd2, 16'h0050, 5'd1, '0, 0, 0, 1);
        check("R11 i2c nack", DW'(result), 4);
        check("R11 i2c nack count", DW'(rd_count), 0);
        fill(3'd0, 8'hC0, 5'd1, RX_PAT);
        run(2'd2, 16'h0050, 5'd1, '0, 0, 0, 1);
        check("R11 i2c invalid", DW'(result), 4);
        fill(3'd0, 8'h80, 5'd1, RX_PAT);
        slot(1, 3'd0, 8'h00);
        run(2'd2, 16'h0050, 5'd1, '0, 0, 0, 1);
        check("R11 i2c defer result", DW'(result), 0);
        check("R11 i2c defer attempts", DW'(n_req), 2);
        check_range("R11 i2c defer wait", gap[1], (DUS - 1) * CPU + 2, DUS * CPU + 1);
        check("R11 i2c defer data", rd_data, DW'(RX_PAT[7:0]));

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule